// File: doc/BRIEF.md
# System control register bank

This block is a small word-addressed register bank that sits on a system control bus. It holds read-only identification words: a system identifier, a capability word and a board strapping word. All three are fixed at build time and loaded when reset is applied. It also holds a configuration-port word, whose ready flag is set from reset onward, and a write-only reset trigger slot.

Writes to the configuration port are decoded on their low command field. The recognised shutdown command produces a one-cycle shutdown request. Any write to the reset trigger slot produces a one-cycle system reset request. Writes to the identification words leave them unchanged and raise a one-cycle access error. Reads or writes of addresses that hold no register also raise the error. Reads of those addresses, and reads of the write-only trigger slot, return zero.

Reads are registered. The value appears on `rdata` in the cycle after `rd_en` is sampled, and `rdata` holds its value while no read is issued. When `wr_en` and `rd_en` are both high in the same cycle, the write is performed and the read is dropped.

Top module: `sysctl_regbank`

## Requirements
- R1: A read of word address 0 returns the system identifier parameter (default 0x10014d31) one cycle after `rd_en`.
- R2: A read of word address 1 returns the capability parameter (default 0x00000000).
- R3: A read of word address 2 returns the strapping parameter (default 0x00000001).
- R4: A read of word address 3 returns the configuration-port word, whose bit 0 is the ready flag. After reset this word reads 0x00000001, and writes to it never change what it reads.
- R5: A write to word address 3 whose bits 15:0 equal the shutdown command parameter (default 0x000E) sets `shutdown_req` high for exactly the next cycle. Any other value on those bits produces no request.
- R6: Any write to word address 4 sets `sys_reset_req` high for exactly the next cycle, whatever the write data.
- R7: A write to word address 0, 1 or 2 raises `access_err` for the next cycle and leaves the value read from that address unchanged.
- R8: Any read or write of a word address of 5 or above raises `access_err` for the next cycle, and such a read returns zero. A read of word address 4 also returns zero and raises `access_err`.
- R9: `sys_reset_req`, `shutdown_req` and `access_err` are single-cycle pulses. They are low out of reset and low in any cycle that follows an access that does not cause them.
- R10: `rdata` is zero out of reset and changes only in the cycle after a read. When a write and a read are requested together, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the identification words |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| sys_reset_req | output | 1 | System reset request pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| access_err | output | 1 | Error pulse for read-only, write-only or unmapped access |

## Verification
The bench keeps the default identifier and shutdown command. It overrides the capability word with 0xA5A50F0F and the strapping word with 0x00000005. With those values, a word stuck at zero, a swapped identification slot or a wrong strap bit shows up as a wrong read. The 3-bit address reaches three unmapped words above the trigger slot, so the unmapped-access error path is exercised. Random write data is biased so that about a quarter of configuration-port writes carry the shutdown command. This covers both matching writes and writes that differ only in their high bits.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // Word slots; the order matters only for the read-only range check.
   localparam int SLOT_IDENT  = 0;
   localparam int SLOT_CAPS   = 1;
   localparam int SLOT_STRAP  = 2;
   localparam int SLOT_CFG    = 3;
   localparam int SLOT_TRIG   = 4;
   localparam int SLOT_COUNT  = 5;

   // Number of words that are held in the identification bank.
   localparam int BANK_WORDS  = 4;

   typedef struct packed {
      logic ident;
      logic caps;
      logic strap;
      logic cfg;
      logic trig;
      logic unmapped;
   } slot_hit_t;

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 3
)(
   input  logic [ADDR_W-1:0] addr,
   output slot_hit_t         hit
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_SPAN < SLOT_COUNT) begin : g_addr_too_small
         $error("sysctl_addr_decode: ADDR_W cannot reach every slot");
      end
   endgenerate

   always_comb begin
      hit = '0;
      case (int'(addr))
         SLOT_IDENT: hit.ident = 1'b1;
         SLOT_CAPS:  hit.caps  = 1'b1;
         SLOT_STRAP: hit.strap = 1'b1;
         SLOT_CFG:   hit.cfg   = 1'b1;
         SLOT_TRIG:  hit.trig  = 1'b1;
         default:    hit.unmapped = 1'b1;
      endcase
   end

endmodule

// File: rtl/sysctl_ident_bank.sv
module sysctl_ident_bank
   import sysctl_pkg::*;
#(
   parameter int              DATA_W      = 32,
   parameter logic [DATA_W-1:0] IDENT_VALUE = 32'h10014d31,
   parameter logic [DATA_W-1:0] CAPS_VALUE  = '0,
   parameter logic [DATA_W-1:0] STRAP_VALUE = 32'h00000001,
   parameter int              READY_BIT   = 0
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(BANK_WORDS)-1:0] sel,
   output logic [DATA_W-1:0]             word
);

   localparam logic [DATA_W-1:0] CFG_INIT = DATA_W'(1) << READY_BIT;
   localparam logic [DATA_W-1:0] INIT_VALS [BANK_WORDS] =
      '{IDENT_VALUE, CAPS_VALUE, STRAP_VALUE, CFG_INIT};

   logic [DATA_W-1:0] bank_q [BANK_WORDS];

   generate
      for (genvar gi = 0; gi < BANK_WORDS; gi++) begin : g_word
         // Loaded by reset only; no bus path ever writes these.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[gi] <= INIT_VALS[gi];
            else        bank_q[gi] <= bank_q[gi];
         end
      end
   endgenerate

   assign word = bank_q[sel];

endmodule

// File: rtl/sysctl_cmd_pulse.sv
module sysctl_cmd_pulse
   import sysctl_pkg::*;
#(
   parameter int             CMD_W        = 16,
   parameter logic [CMD_W-1:0] SHUTDOWN_CMD = 16'h000E
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  slot_hit_t        hit,
   input  logic [CMD_W-1:0] cmd,
   output logic             sys_reset_req,
   output logic             shutdown_req,
   output logic             access_err
);

   logic rd_only;
   logic wr_readonly;
   logic rd_bad;
   logic trig_next;
   logic shut_next;
   logic err_next;

   always_comb begin
      rd_only     = rd_en && !wr_en;
      wr_readonly = hit.ident || hit.caps || hit.strap;
      rd_bad      = hit.trig || hit.unmapped;
      trig_next   = wr_en && hit.trig;
      shut_next   = wr_en && hit.cfg && (cmd == SHUTDOWN_CMD);
      err_next    = (wr_en && (wr_readonly || hit.unmapped)) ||
                    (rd_only && rd_bad);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_reset_req <= 1'b0;
         shutdown_req  <= 1'b0;
         access_err    <= 1'b0;
      end else begin
         sys_reset_req <= trig_next;
         shutdown_req  <= shut_next;
         access_err    <= err_next;
      end
   end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int                DATA_W       = 32,
   parameter int                ADDR_W       = 3,
   parameter int                CMD_W        = 16,
   parameter int                READY_BIT    = 0,
   parameter logic [DATA_W-1:0] IDENT_VALUE  = 32'h10014d31,
   parameter logic [DATA_W-1:0] CAPS_VALUE   = 32'h00000000,
   parameter logic [DATA_W-1:0] STRAP_VALUE  = 32'h00000001,
   parameter logic [CMD_W-1:0]  SHUTDOWN_CMD = 16'h000E
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sys_reset_req,
   output logic              shutdown_req,
   output logic              access_err
);

   localparam int SEL_W = $clog2(BANK_WORDS);

   generate
      if (CMD_W > DATA_W) begin : g_bad_cmd_w
         $error("sysctl_regbank: CMD_W exceeds DATA_W");
      end
      if (READY_BIT >= DATA_W) begin : g_bad_ready
         $error("sysctl_regbank: READY_BIT outside the data word");
      end
   endgenerate

   slot_hit_t         hit;
   logic [SEL_W-1:0]  bank_sel;
   logic [DATA_W-1:0] bank_word;
   logic              bank_hit;
   logic [DATA_W-1:0] rd_next;

   sysctl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .hit  (hit)
   );

   always_comb begin
      bank_hit = hit.ident || hit.caps || hit.strap || hit.cfg;
      if (hit.caps)       bank_sel = SEL_W'(SLOT_CAPS);
      else if (hit.strap) bank_sel = SEL_W'(SLOT_STRAP);
      else if (hit.cfg)   bank_sel = SEL_W'(SLOT_CFG);
      else                bank_sel = SEL_W'(SLOT_IDENT);
      rd_next = bank_hit ? bank_word : '0;
   end

   sysctl_ident_bank #(
      .DATA_W      (DATA_W),
      .IDENT_VALUE (IDENT_VALUE),
      .CAPS_VALUE  (CAPS_VALUE),
      .STRAP_VALUE (STRAP_VALUE),
      .READY_BIT   (READY_BIT)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bank_sel),
      .word  (bank_word)
   );

   sysctl_cmd_pulse #(
      .CMD_W        (CMD_W),
      .SHUTDOWN_CMD (SHUTDOWN_CMD)
   ) u_pulse (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .rd_en         (rd_en),
      .hit           (hit),
      .cmd           (wdata[CMD_W-1:0]),
      .sys_reset_req (sys_reset_req),
      .shutdown_req  (shutdown_req),
      .access_err    (access_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata <= '0;
      else if (rd_en && !wr_en)  rdata <= rd_next;
   end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int                DATA_W       = 32,
   parameter int                ADDR_W       = 3,
   parameter int                CMD_W        = 16,
   parameter logic [DATA_W-1:0] IDENT_VALUE  = 32'h10014d31,
   parameter logic [CMD_W-1:0]  SHUTDOWN_CMD = 16'h000E
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              sys_reset_req,
   input logic              shutdown_req,
   input logic              access_err
);

   assert_ident_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && int'(addr) == 0) |=> (rdata == IDENT_VALUE));

   assert_shutdown_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) == 3 && wdata[CMD_W-1:0] == SHUTDOWN_CMD) |=> shutdown_req);

   assert_shutdown_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown_req) |-> $past(wr_en && int'(addr) == 3));

   assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) == 4) |=> sys_reset_req);

   assert_ro_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) < 3) |=> access_err);

   assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && int'(addr) >= 5) |=> (rdata == '0 && access_err));

   assert_requests_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sys_reset_req, shutdown_req}));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !wr_en) |=> $stable(rdata));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .CMD_W        (CMD_W),
   .IDENT_VALUE  (IDENT_VALUE),
   .SHUTDOWN_CMD (SHUTDOWN_CMD)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .rd_en         (rd_en),
   .addr          (addr),
   .wdata         (wdata),
   .rdata         (rdata),
   .sys_reset_req (sys_reset_req),
   .shutdown_req  (shutdown_req),
   .access_err    (access_err)
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] EXP_IDENT  = 32'h10014d31;
   localparam logic [31:0] EXP_CAPS   = 32'hA5A50F0F;
   localparam logic [31:0] EXP_STRAP  = 32'h00000005;
   localparam logic [15:0] EXP_SHUT   = 16'h000E;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic        rd_en;
   logic [2:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        sys_reset_req;
   logic        shutdown_req;
   logic        access_err;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regbank #(
      .CAPS_VALUE  (EXP_CAPS),
      .STRAP_VALUE (EXP_STRAP)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .rd_en         (rd_en),
      .addr          (addr),
      .wdata         (wdata),
      .rdata         (rdata),
      .sys_reset_req (sys_reset_req),
      .shutdown_req  (shutdown_req),
      .access_err    (access_err)
   );

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0:    return EXP_IDENT;
         3'd1:    return EXP_CAPS;
         3'd2:    return EXP_STRAP;
         3'd3:    return 32'h00000001;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_err(input logic is_wr, input logic [2:0] a);
      if (is_wr) return (a <= 3'd2) || (a >= 3'd5);
      return a >= 3'd4;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic is_wr, input logic is_rd, input logic [2:0] a,
                         input logic [31:0] d);
      logic [31:0] prev;
      prev = rdata;
      @(negedge clk);
      wr_en = is_wr; rd_en = is_rd; addr = a; wdata = d;
      @(posedge clk); #1;
      if (is_rd && !is_wr) check(a == 0 ? "R1" : a == 1 ? "R2" : a == 2 ? "R3" :
                                 a == 3 ? "R4" : "R8", rdata, exp_read(a));
      else check("R10", rdata, prev);
      check("R6", {31'b0, sys_reset_req}, {31'b0, is_wr && a == 3'd4});
      check("R5", {31'b0, shutdown_req},
            {31'b0, is_wr && a == 3'd3 && d[15:0] == EXP_SHUT});
      check(is_wr && a <= 3'd2 ? "R7" : "R8", {31'b0, access_err},
            {31'b0, exp_err(is_wr, a) && (is_wr || is_rd)});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      @(posedge clk); #1;
      check("R9", {29'b0, sys_reset_req, shutdown_req, access_err}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
      repeat (4) @(posedge clk);
      #1;
      check("R10", rdata, 32'h0);
      check("R9", {29'b0, sys_reset_req, shutdown_req, access_err}, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // Directed corner cases
      for (int a = 0; a < 8; a++) access(1'b0, 1'b1, 3'(a), '0);       // R1 R2 R3 R4 R8
      access(1'b1, 1'b0, 3'd3, 32'hFFFF_000E);                          // R5 high bits ignored
      access(1'b1, 1'b0, 3'd3, 32'h0000_000F);                          // R5 no match
      access(1'b0, 1'b1, 3'd3, '0);                                     // R4 unchanged
      access(1'b1, 1'b0, 3'd4, 32'h0);                                  // R6
      access(1'b1, 1'b0, 3'd4, 32'hDEAD_BEEF);                          // R6
      for (int a = 0; a < 3; a++) begin                                 // R7
         access(1'b1, 1'b0, 3'(a), 32'h5555_AAAA);
         access(1'b0, 1'b1, 3'(a), '0);
      end
      access(1'b1, 1'b0, 3'd6, 32'h1);                                  // R8 unmapped write
      access(1'b1, 1'b1, 3'd0, 32'h0);                                  // R10 write wins

      // Constrained random
      for (int i = 0; i < 300; i++) begin
         logic [1:0]  op;
         logic [31:0] d;
         op = 2'($urandom_range(0, 3));
         d  = $urandom;
         if ($urandom_range(0, 3) == 0) d[15:0] = EXP_SHUT;
         access(op[0], op[1] | ~op[0], 3'($urandom_range(0, 7)), d);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule